// File: doc/BRIEF.md
# Contiguous Write Coalescing Buffer

The block gathers a run of small write pieces into one memory write of up to 16 bytes and issues that write downstream as a single request. Each piece carries a start address, a byte count, an access-kind code, an exclusive flag and up to 128 bits of data, of which only the low byte-count bytes are used. The first piece after an empty state opens the buffer. Every later piece must continue the same access: the same kind, the same exclusive flag, and a start address equal to the end of the bytes already held. Its bytes are placed directly above those bytes.

A flush command turns the held bytes into one downstream request. The request carries the opening address, the total size, the merged data and a request class derived from the kind and the exclusive flag. The request uses a valid/ready handshake. A non-exclusive write completes on the handshake. An exclusive write waits for a one-cycle response whose success bit is passed back on a completion strobe. Any rule violation raises a one-cycle error flag.

Top module: `write_coalesce_buffer`

## Requirements
- R1: After reset the buffer is empty; `reqValid`, `errFlag` and `doneValid` are 0 and `pieceReady` is 1.
- R2: A piece accepted while the buffer is empty stores its address, kind, exclusive flag and byte count. Its data is zero-extended: only bytes below the byte count are kept and all higher request data bits read as 0.
- R3: A piece is appended when it has the held kind and exclusive flag and starts at held address plus held size. Its bytes land at byte offset (held size) of the data, and the size grows by the piece size.
- R4: A piece that differs in kind or exclusive flag, or that does not start at the held end address, raises `errFlag` for one cycle, starting on the cycle after it is sampled. Such a piece leaves the buffer unchanged.
- R5: A piece whose byte count is not 1, 2, 4, 8 or 16, or one that would take the total past 16 bytes, raises `errFlag` and leaves the buffer unchanged.
- R6: Kind codes are normal=0, stream=1, unprivileged=2, ordered=3 and atomic=4. A flushed request gets `reqClass` plain=0 for non-exclusive kinds 0..2, release=1 for non-exclusive ordered, exclusive=2 for exclusive atomic, and exclusive-release=3 for exclusive ordered. `reqExcl` equals the held exclusive flag.
- R7: A flush is rejected in three cases: the buffer is empty, the total size is not 1, 2, 4, 8 or 16, or the kind/exclusive pair is not listed in R6. A rejected flush raises `errFlag`, issues no request and leaves the buffer empty.
- R8: A request sampled with `reqReady` low is presented again on the next cycle with the same address, size, class and data.
- R9: A non-exclusive request completes on its handshake: `doneValid` pulses on the next cycle with `doneOk`=1, and the buffer is empty.
- R10: An exclusive request waits after its handshake until `rspValid`. `doneValid` then pulses on the next cycle with `doneOk` equal to the sampled `rspOk`, and the buffer is empty.
- R11: `pieceReady` is low while `flushReq` is high or a request is outstanding. A piece offered then is ignored: it raises no error and leaves the buffer unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| pieceValid | input | 1 | A write piece is offered |
| pieceReady | output | 1 | Pieces are taken this cycle |
| pieceAddr | input | 32 | Piece start address |
| pieceSize | input | 5 | Piece byte count |
| pieceKind | input | 3 | Piece access-kind code |
| pieceExcl | input | 1 | Piece exclusive flag |
| pieceData | input | 128 | Piece data, low bytes used |
| flushReq | input | 1 | Issue the held bytes as one request |
| errFlag | output | 1 | One-cycle rule-violation pulse |
| reqValid | output | 1 | Downstream request valid |
| reqReady | input | 1 | Downstream accepts request |
| reqAddr | output | 32 | Request start address |
| reqSize | output | 5 | Request byte count |
| reqClass | output | 2 | Request class code |
| reqExcl | output | 1 | Request is exclusive |
| reqData | output | 128 | Merged request data |
| rspValid | input | 1 | Exclusive response strobe |
| rspOk | input | 1 | Exclusive success bit |
| doneValid | output | 1 | Write completed |
| doneOk | output | 1 | Completion success bit |

## Verification
The hardest situation to reach is a piece that arrives while the block cannot take it. This happens in the same cycle as a flush, or while a request waits on a stalled downstream. The ignored piece must leave no trace in the merged data. The stimulus holds `reqReady` low after a flush, offers a piece into the stall, and watches the stalled request for changes. A piece raised together with `flushReq` must be absent from the issued size and data, and a later flush of the emptied buffer must be rejected.

// File: rtl/wcb_pkg.sv
package wcb_pkg;

  typedef enum logic [2:0] {
    KIND_NORMAL  = 3'd0,
    KIND_STREAM  = 3'd1,
    KIND_UNPRIV  = 3'd2,
    KIND_ORDERED = 3'd3,
    KIND_ATOMIC  = 3'd4
  } accessKind_e;

  typedef enum logic [1:0] {
    CLS_PLAIN        = 2'd0,
    CLS_RELEASE      = 2'd1,
    CLS_EXCL         = 2'd2,
    CLS_EXCL_RELEASE = 2'd3
  } reqClass_e;

  // strobes from control to datapath
  typedef struct packed {
    logic load;
    logic append;
    logic clear;
  } dpStrobe_t;

  function automatic logic [1:0] classOf(input logic [2:0] kind, input logic excl);
    logic ordered;
    ordered = (kind == KIND_ORDERED);
    if (excl) return ordered ? CLS_EXCL_RELEASE : CLS_EXCL;
    return ordered ? CLS_RELEASE : CLS_PLAIN;
  endfunction

endpackage

// File: rtl/wcb_datapath.sv
module wcb_datapath
  import wcb_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int BYTES  = 16,
  localparam int DATA_W = BYTES * 8,
  localparam int SIZE_W = $clog2(BYTES) + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strb,
  input  logic [ADDR_W-1:0] pieceAddr,
  input  logic [SIZE_W-1:0] pieceSize,
  input  logic [2:0]        pieceKind,
  input  logic              pieceExcl,
  input  logic [DATA_W-1:0] pieceData,
  output logic [ADDR_W-1:0] heldAddr,
  output logic [SIZE_W-1:0] heldSize,
  output logic [2:0]        heldKind,
  output logic              heldExcl,
  output logic [DATA_W-1:0] heldData,
  output logic [1:0]        heldClass
);

  logic [DATA_W-1:0] pieceMasked;
  logic [DATA_W-1:0] pieceShifted;

  // keep only bytes below the piece byte count
  for (genvar b = 0; b < BYTES; b++) begin : g_byteMask
    assign pieceMasked[b*8 +: 8] = (pieceSize > SIZE_W'(b)) ? pieceData[b*8 +: 8] : 8'h00;
  end

  assign pieceShifted = pieceMasked << {heldSize, 3'b000};
  assign heldClass    = classOf(heldKind, heldExcl);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      heldAddr <= '0;
      heldSize <= '0;
      heldKind <= '0;
      heldExcl <= 1'b0;
      heldData <= '0;
    end else if (strb.clear) begin
      heldSize <= '0;
      heldData <= '0;
    end else if (strb.load) begin
      heldAddr <= pieceAddr;
      heldSize <= pieceSize;
      heldKind <= pieceKind;
      heldExcl <= pieceExcl;
      heldData <= pieceMasked;
    end else if (strb.append) begin
      heldSize <= heldSize + pieceSize;
      heldData <= heldData | pieceShifted;
    end
  end

  AST_SIZE_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    heldSize <= SIZE_W'(BYTES)) else $error("held size past capacity"); // R5

endmodule

// File: rtl/wcb_control.sv
module wcb_control
  import wcb_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int BYTES  = 16,
  localparam int SIZE_W = $clog2(BYTES) + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              pieceValid,
  input  logic [ADDR_W-1:0] pieceAddr,
  input  logic [SIZE_W-1:0] pieceSize,
  input  logic [2:0]        pieceKind,
  input  logic              pieceExcl,
  input  logic              flushReq,
  input  logic [ADDR_W-1:0] heldAddr,
  input  logic [SIZE_W-1:0] heldSize,
  input  logic [2:0]        heldKind,
  input  logic              heldExcl,
  input  logic              reqReady,
  input  logic              rspValid,
  input  logic              rspOk,
  output dpStrobe_t         strb,
  output logic              pieceReady,
  output logic              reqValid,
  output logic              errFlag,
  output logic              doneValid,
  output logic              doneOk
);

  typedef enum logic [1:0] {ST_COLLECT, ST_ISSUE, ST_WAIT} ctrlState_e;

  ctrlState_e state, stateNext;

  logic              collecting;
  logic              pieceTake;
  logic              pieceSizeOk;
  logic              bufEmpty;
  logic [SIZE_W:0]   sumSize;
  logic [ADDR_W-1:0] endAddr;
  logic              contiguousOk;
  logic              pieceErr;
  logic              flushTake;
  logic              kindOk;
  logic              flushLegal;
  logic              flushErr;
  logic              doneSet;
  logic              doneOkNext;

  assign collecting  = (state == ST_COLLECT);
  assign pieceReady  = collecting && !flushReq;
  assign pieceTake   = pieceValid && pieceReady;
  assign pieceSizeOk = $onehot(pieceSize);
  assign bufEmpty    = (heldSize == '0);
  assign sumSize     = {1'b0, heldSize} + {1'b0, pieceSize};
  assign endAddr     = heldAddr + ADDR_W'(heldSize);

  assign contiguousOk = !bufEmpty
                     && (pieceKind == heldKind)
                     && (pieceExcl == heldExcl)
                     && (pieceAddr == endAddr)
                     && (sumSize <= (SIZE_W+1)'(BYTES));

  assign kindOk = heldExcl ? (heldKind == KIND_ATOMIC || heldKind == KIND_ORDERED)
                           : (heldKind <= KIND_ORDERED);

  assign flushTake  = collecting && flushReq;
  assign flushLegal = !bufEmpty && $onehot(heldSize) && kindOk;
  assign flushErr   = flushTake && !flushLegal;

  always_comb begin
    strb        = '0;
    strb.load   = pieceTake && pieceSizeOk && bufEmpty;
    strb.append = pieceTake && pieceSizeOk && contiguousOk;
    pieceErr    = pieceTake && !(strb.load || strb.append);
    stateNext   = state;
    doneSet     = 1'b0;
    doneOkNext  = 1'b0;
    unique case (state)
      ST_COLLECT: begin
        if (flushTake) begin
          if (flushLegal) stateNext = ST_ISSUE;
          else            strb.clear = 1'b1;
        end
      end
      ST_ISSUE: begin
        if (reqReady) begin
          if (heldExcl) begin
            stateNext = ST_WAIT;
          end else begin
            stateNext  = ST_COLLECT;
            strb.clear = 1'b1;
            doneSet    = 1'b1;
            doneOkNext = 1'b1;
          end
        end
      end
      ST_WAIT: begin
        if (rspValid) begin
          stateNext  = ST_COLLECT;
          strb.clear = 1'b1;
          doneSet    = 1'b1;
          doneOkNext = rspOk;
        end
      end
      default: stateNext = ST_COLLECT;
    endcase
  end

  assign reqValid = (state == ST_ISSUE);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_COLLECT;
      errFlag   <= 1'b0;
      doneValid <= 1'b0;
      doneOk    <= 1'b0;
    end else begin
      state     <= stateNext;
      errFlag   <= pieceErr || flushErr;
      doneValid <= doneSet;
      doneOk    <= doneOkNext;
    end
  end

  AST_WAIT_HAS_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_WAIT) |-> heldExcl) else $error("response wait without exclusive"); // R10

  AST_REJECT_KEEPS: assert property (@(posedge clk) disable iff (!rstN)
    (pieceErr && !flushTake) |=> $stable(heldSize)) else $error("rejected piece changed size"); // R4

endmodule

// File: rtl/write_coalesce_buffer.sv
module write_coalesce_buffer
  import wcb_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int BYTES  = 16,
  localparam int DATA_W = BYTES * 8,
  localparam int SIZE_W = $clog2(BYTES) + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              pieceValid,
  output logic              pieceReady,
  input  logic [ADDR_W-1:0] pieceAddr,
  input  logic [SIZE_W-1:0] pieceSize,
  input  logic [2:0]        pieceKind,
  input  logic              pieceExcl,
  input  logic [DATA_W-1:0] pieceData,
  input  logic              flushReq,
  output logic              errFlag,
  output logic              reqValid,
  input  logic              reqReady,
  output logic [ADDR_W-1:0] reqAddr,
  output logic [SIZE_W-1:0] reqSize,
  output logic [1:0]        reqClass,
  output logic              reqExcl,
  output logic [DATA_W-1:0] reqData,
  input  logic              rspValid,
  input  logic              rspOk,
  output logic              doneValid,
  output logic              doneOk
);

  dpStrobe_t         strb;
  logic [ADDR_W-1:0] heldAddr;
  logic [SIZE_W-1:0] heldSize;
  logic [2:0]        heldKind;
  logic              heldExcl;
  logic [DATA_W-1:0] heldData;
  logic [1:0]        heldClass;

  wcb_control #(.ADDR_W(ADDR_W), .BYTES(BYTES)) i_control (
    .clk        (clk),
    .rstN       (rstN),
    .pieceValid (pieceValid),
    .pieceAddr  (pieceAddr),
    .pieceSize  (pieceSize),
    .pieceKind  (pieceKind),
    .pieceExcl  (pieceExcl),
    .flushReq   (flushReq),
    .heldAddr   (heldAddr),
    .heldSize   (heldSize),
    .heldKind   (heldKind),
    .heldExcl   (heldExcl),
    .reqReady   (reqReady),
    .rspValid   (rspValid),
    .rspOk      (rspOk),
    .strb       (strb),
    .pieceReady (pieceReady),
    .reqValid   (reqValid),
    .errFlag    (errFlag),
    .doneValid  (doneValid),
    .doneOk     (doneOk)
  );

  wcb_datapath #(.ADDR_W(ADDR_W), .BYTES(BYTES)) i_datapath (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .pieceAddr (pieceAddr),
    .pieceSize (pieceSize),
    .pieceKind (pieceKind),
    .pieceExcl (pieceExcl),
    .pieceData (pieceData),
    .heldAddr  (heldAddr),
    .heldSize  (heldSize),
    .heldKind  (heldKind),
    .heldExcl  (heldExcl),
    .heldData  (heldData),
    .heldClass (heldClass)
  );

  assign reqAddr  = heldAddr;
  assign reqSize  = heldSize;
  assign reqClass = heldClass;
  assign reqExcl  = heldExcl;
  assign reqData  = heldData;

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !reqReady) |=> (reqValid && $stable(reqAddr) && $stable(reqSize)
                                 && $stable(reqClass) && $stable(reqData)))
    else $error("stalled request changed"); // R8

  AST_CLASS_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |-> (reqClass[1] == reqExcl)) else $error("class and exclusive disagree"); // R6

  AST_ISSUE_LEGAL: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |-> $onehot(reqSize)) else $error("request with illegal size"); // R7

  AST_DONE_EMPTY: assert property (@(posedge clk) disable iff (!rstN)
    doneValid |-> (reqSize == '0)) else $error("buffer not empty after completion"); // R9

  AST_BUSY_NO_PIECE: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |-> !pieceReady) else $error("pieces taken while request outstanding"); // R11

endmodule

// File: tb/test_write_coalesce_buffer.sv
`timescale 1ns/1ps
module test_write_coalesce_buffer;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         pieceValid = 1'b0;
  logic         pieceReady;
  logic [31:0]  pieceAddr = '0;
  logic [4:0]   pieceSize = '0;
  logic [2:0]   pieceKind = '0;
  logic         pieceExcl = 1'b0;
  logic [127:0] pieceData = '0;
  logic         flushReq = 1'b0;
  logic         errFlag;
  logic         reqValid;
  logic         reqReady = 1'b1;
  logic [31:0]  reqAddr;
  logic [4:0]   reqSize;
  logic [1:0]   reqClass;
  logic         reqExcl;
  logic [127:0] reqData;
  logic         rspValid = 1'b0;
  logic         rspOk = 1'b0;
  logic         doneValid;
  logic         doneOk;

  always #2.5 clk = ~clk;

  write_coalesce_buffer i_write_coalesce_buffer (.*);

  int testsRun = 0;
  int testsFailed = 0;

  typedef struct {
    logic [31:0]  addr;
    logic [4:0]   size;
    logic [127:0] data;
    logic [1:0]   cls;
    logic         excl;
    string        tag;
  } expReq_t;

  expReq_t reqQ[$];
  bit      doneQ[$];
  bit      nextRspOk = 1'b0;
  bit      rspArm = 1'b0;

  task automatic check(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
    testsRun++;
    if (!ok) begin
      testsFailed++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic expectReq(input logic [31:0] a, input logic [4:0] s, input logic [127:0] d,
                           input logic [1:0] c, input logic x, input bit ok, input string tag);
    expReq_t e;
    e.addr = a; e.size = s; e.data = d; e.cls = c; e.excl = x; e.tag = tag;
    reqQ.push_back(e);
    doneQ.push_back(ok);
  endtask

  // monitor: compare each handshaken request against the scoreboard
  always @(negedge clk) begin
    if (rstN && reqValid && reqReady) begin
      if (reqQ.size() == 0) begin
        check(1'b0, "R7 unexpected request", {96'd0, reqAddr}, 128'd0);
      end else begin
        expReq_t e;
        e = reqQ.pop_front();
        check(reqAddr == e.addr, {e.tag, " addr"}, {96'd0, reqAddr}, {96'd0, e.addr});
        check(reqSize == e.size, {e.tag, " size"}, {123'd0, reqSize}, {123'd0, e.size});
        check(reqData == e.data, {e.tag, " data"}, reqData, e.data);
        check(reqClass == e.cls, {e.tag, " class R6"}, {126'd0, reqClass}, {126'd0, e.cls});
        check(reqExcl == e.excl, {e.tag, " excl R6"}, {127'd0, reqExcl}, {127'd0, e.excl});
      end
      if (reqExcl) rspArm = 1'b1;
    end
  end

  // responder: one-cycle exclusive response after the handshake
  always @(posedge clk) begin
    #1;
    if (rspArm) begin
      rspValid = 1'b1;
      rspOk    = nextRspOk;
      rspArm   = 1'b0;
    end else begin
      rspValid = 1'b0;
      rspOk    = 1'b0;
    end
  end

  always @(negedge clk) begin
    if (rstN && doneValid) begin
      if (doneQ.size() == 0) begin
        check(1'b0, "R9 unexpected completion", {127'd0, doneOk}, 128'd0);
      end else begin
        bit e;
        e = doneQ.pop_front();
        check(doneOk == e, "R9 R10 done status", {127'd0, doneOk}, {127'd0, e});
        check(reqSize == 5'd0, "R9 empty after done", {123'd0, reqSize}, 128'd0);
      end
    end
  end

  task automatic putPiece(input logic [31:0] a, input logic [4:0] s, input logic [2:0] k,
                          input logic x, input logic [127:0] d, input bit withFlush, output bit err);
    @(posedge clk); #1;
    pieceValid = 1'b1; pieceAddr = a; pieceSize = s; pieceKind = k; pieceExcl = x; pieceData = d;
    flushReq = withFlush;
    @(posedge clk); #1;
    pieceValid = 1'b0; flushReq = 1'b0;
    @(negedge clk);
    err = errFlag;
  endtask

  task automatic doFlush(output bit err);
    @(posedge clk); #1;
    flushReq = 1'b1;
    @(posedge clk); #1;
    flushReq = 1'b0;
    @(negedge clk);
    err = errFlag;
  endtask

  task automatic waitIdle();
    for (int i = 0; i < 50; i++) begin
      if (pieceReady && !reqValid) break;
      @(negedge clk);
    end
  endtask

  initial begin
    #1_000_000;
    testsRun++;
    testsFailed++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    bit err;
    logic [31:0]  hAddr;
    logic [4:0]   hSize;
    logic [127:0] hData;

    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    @(negedge clk);
    check(reqValid == 1'b0, "R1 reqValid", {127'd0, reqValid}, 128'd0);
    check(errFlag == 1'b0, "R1 errFlag", {127'd0, errFlag}, 128'd0);
    check(doneValid == 1'b0, "R1 doneValid", {127'd0, doneValid}, 128'd0);
    check(pieceReady == 1'b1, "R1 pieceReady", {127'd0, pieceReady}, 128'd1);

    // R2: single piece, high garbage stripped
    putPiece(32'h40, 5'd4, 3'd0, 1'b0, 128'hFFFF_FFFF_FFFF_FFFF_FFFF_FFFF_DDCC_BBAA, 1'b0, err);
    check(!err, "R2 open accepted", {127'd0, err}, 128'd0);
    expectReq(32'h40, 5'd4, 128'hDDCC_BBAA, 2'd0, 1'b0, 1'b1, "R2");
    doFlush(err);
    check(!err, "R2 flush accepted", {127'd0, err}, 128'd0);
    waitIdle();

    // R3: stream kind append
    putPiece(32'h100, 5'd4, 3'd1, 1'b0, 128'h1122_3344, 1'b0, err);
    putPiece(32'h104, 5'd4, 3'd1, 1'b0, 128'h5566_7788, 1'b0, err);
    check(!err, "R3 append accepted", {127'd0, err}, 128'd0);
    expectReq(32'h100, 5'd8, 128'h5566_7788_1122_3344, 2'd0, 1'b0, 1'b1, "R3");
    doFlush(err);
    waitIdle();

    // R6: ordered non-exclusive gives release class
    putPiece(32'h200, 5'd2, 3'd3, 1'b0, 128'hAABB, 1'b0, err);
    putPiece(32'h202, 5'd2, 3'd3, 1'b0, 128'hCCDD, 1'b0, err);
    expectReq(32'h200, 5'd4, 128'hCCDD_AABB, 2'd1, 1'b0, 1'b1, "R6 release");
    doFlush(err);
    waitIdle();

    // R6: unprivileged kind is plain
    putPiece(32'h280, 5'd1, 3'd2, 1'b0, 128'h5A, 1'b0, err);
    expectReq(32'h280, 5'd1, 128'h5A, 2'd0, 1'b0, 1'b1, "R6 unpriv");
    doFlush(err);
    waitIdle();

    // R7: total of 3 bytes cannot be flushed
    putPiece(32'h300, 5'd1, 3'd0, 1'b0, 128'h11, 1'b0, err);
    putPiece(32'h301, 5'd2, 3'd0, 1'b0, 128'h2233, 1'b0, err);
    check(!err, "R7 odd total merge accepted", {127'd0, err}, 128'd0);
    doFlush(err);
    check(err, "R7 odd total flush rejected", {127'd0, err}, 128'd1);
    doFlush(err);
    check(err, "R7 empty flush rejected", {127'd0, err}, 128'd1);

    // R4: mismatches rejected, buffer unchanged
    putPiece(32'h400, 5'd4, 3'd0, 1'b0, 128'hA1A2_A3A4, 1'b0, err);
    putPiece(32'h408, 5'd4, 3'd0, 1'b0, 128'hEEEE_EEEE, 1'b0, err);
    check(err, "R4 gap address rejected", {127'd0, err}, 128'd1);
    putPiece(32'h404, 5'd4, 3'd1, 1'b0, 128'hEEEE_EEEE, 1'b0, err);
    check(err, "R4 kind mismatch rejected", {127'd0, err}, 128'd1);
    putPiece(32'h404, 5'd4, 3'd0, 1'b1, 128'hEEEE_EEEE, 1'b0, err);
    check(err, "R4 exclusive mismatch rejected", {127'd0, err}, 128'd1);
    putPiece(32'h404, 5'd4, 3'd0, 1'b0, 128'hB1B2_B3B4, 1'b0, err);
    check(!err, "R4 good append after rejects", {127'd0, err}, 128'd0);
    expectReq(32'h400, 5'd8, 128'hB1B2_B3B4_A1A2_A3A4, 2'd0, 1'b0, 1'b1, "R4 unchanged");
    doFlush(err);
    waitIdle();

    // R5: overflow and illegal piece size
    putPiece(32'h500, 5'd8, 3'd0, 1'b0, 128'h0102_0304_0506_0708, 1'b0, err);
    putPiece(32'h508, 5'd16, 3'd0, 1'b0, {128{1'b1}}, 1'b0, err);
    check(err, "R5 overflow rejected", {127'd0, err}, 128'd1);
    putPiece(32'h508, 5'd3, 3'd0, 1'b0, 128'hFFFFFF, 1'b0, err);
    check(err, "R5 size 3 rejected", {127'd0, err}, 128'd1);
    putPiece(32'h508, 5'd8, 3'd0, 1'b0, 128'h1112_1314_1516_1718, 1'b0, err);
    check(!err, "R5 fill to 16 accepted", {127'd0, err}, 128'd0);
    expectReq(32'h500, 5'd16, 128'h1112_1314_1516_1718_0102_0304_0506_0708, 2'd0, 1'b0, 1'b1, "R5 full");
    doFlush(err);
    waitIdle();

    // R10: exclusive atomic success, exclusive ordered failure
    nextRspOk = 1'b1;
    putPiece(32'h600, 5'd8, 3'd4, 1'b1, 128'hCAFE_F00D_1234_5678, 1'b0, err);
    expectReq(32'h600, 5'd8, 128'hCAFE_F00D_1234_5678, 2'd2, 1'b1, 1'b1, "R10 excl");
    doFlush(err);
    check(!err, "R10 exclusive flush accepted", {127'd0, err}, 128'd0);
    waitIdle();
    nextRspOk = 1'b0;
    putPiece(32'h700, 5'd2, 3'd3, 1'b1, 128'hBEEF, 1'b0, err);
    expectReq(32'h700, 5'd2, 128'hBEEF, 2'd3, 1'b1, 1'b0, "R10 excl-release");
    doFlush(err);
    waitIdle();

    // R7: illegal kind/exclusive pairs
    putPiece(32'h780, 5'd4, 3'd0, 1'b1, 128'h1, 1'b0, err);
    doFlush(err);
    check(err, "R7 exclusive normal rejected", {127'd0, err}, 128'd1);
    putPiece(32'h790, 5'd4, 3'd4, 1'b0, 128'h1, 1'b0, err);
    doFlush(err);
    check(err, "R7 plain atomic rejected", {127'd0, err}, 128'd1);

    // R8 / R11: stall the request, offer a piece into the stall
    putPiece(32'h900, 5'd4, 3'd0, 1'b0, 128'h9999_8888, 1'b0, err);
    #1 reqReady = 1'b0;
    doFlush(err);
    hAddr = reqAddr; hSize = reqSize; hData = reqData;
    check(reqValid, "R8 request raised", {127'd0, reqValid}, 128'd1);
    putPiece(32'h904, 5'd4, 3'd0, 1'b0, 128'h7777_6666, 1'b0, err);
    check(!err, "R11 piece during stall no error", {127'd0, err}, 128'd0);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check(reqValid && reqAddr == hAddr && reqSize == hSize && reqData == hData,
            "R8 stalled request stable", reqData, hData);
    end
    expectReq(32'h900, 5'd4, 128'h9999_8888, 2'd0, 1'b0, 1'b1, "R8 R11");
    @(posedge clk); #1 reqReady = 1'b1;
    waitIdle();
    doFlush(err);
    check(err, "R11 stalled piece left nothing", {127'd0, err}, 128'd1);

    // R11: piece together with flush is ignored
    putPiece(32'hA00, 5'd4, 3'd0, 1'b0, 128'h4444_3333, 1'b0, err);
    expectReq(32'hA00, 5'd4, 128'h4444_3333, 2'd0, 1'b0, 1'b1, "R11 same-cycle");
    putPiece(32'hA04, 5'd4, 3'd0, 1'b0, 128'h2222_1111, 1'b1, err);
    check(!err, "R11 same-cycle piece no error", {127'd0, err}, 128'd0);
    waitIdle();
    repeat (3) @(negedge clk);

    check(reqQ.size() == 0, "R9 all requests seen", reqQ.size(), 128'd0);
    check(doneQ.size() == 0, "R10 all completions seen", doneQ.size(), 128'd0);

    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

endmodule